// File: doc/BRIEF.md
# Keyboard-Side Two-Wire Serial Link Transceiver

This block is the device end of a two-wire, open-collector clock/data link of the kind used between a keyboard and its host. The device always generates the clock, whichever way a frame travels. It can send one byte at a time to the host, or accept a byte the host pushes to it. Each frame has 11 bits: a start bit of 0, eight data bits with the least significant bit first, an odd-parity bit, and a stop bit of 1. Both lines are only ever pulled low by the block. A line goes high when nobody pulls it, so the two outputs are pull-low enables.

Between frames the block reads the state of the lines. If the clock is low, the host is inhibiting the link. If the clock is high and data is low, the host wants to send. If both are high, the device may transmit. A receive gets priority over a pending transmit. The transmit side is valid/ready. A byte is taken on the cycle where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, the source must hold `tx_valid` and `tx_data` steady. The receive side has no back-pressure: `rx_valid` is a one-cycle strobe, and the consumer must capture `rx_data` and `rx_par_err` on that cycle.

Each clock phase lasts `HALF_CYC` system clocks. The default of 4000 gives 40 µs at 100 MHz. After every frame the block waits one extra half-period before it looks at the lines again. Interpreting the bytes as commands is left to the logic around the block.

Top module: `kbd_link_phy`

## Requirements
- R1: `tx_ready` is high only while the block is idle and both synchronised lines are high. If the host holds the clock line low, `tx_ready` stays low. If the clock is high and data is low, the block starts a receive and does not transmit.
- R2: A transmitted frame shows, on the data line at successive clock falling edges: 0, data bits 0 to 7, the parity bit, then 1. Data changes only while the clock is released. `tx_done` pulses once, one half-period after the eleventh falling edge.
- R3: The transmitted parity bit makes the count of ones across the eight data bits and the parity bit odd.
- R4: If the host holds the clock low at the end of a released-clock phase that comes before the tenth falling edge of a transmit, the block releases both lines and pulses `tx_abort`, and `tx_done` does not pulse for that frame.
- R5: Every clock-low phase the block generates lasts exactly `HALF_CYC` system clocks.
- R6: On a receive, the block gives ten clock pulses and samples data at the end of each released phase. If the tenth sample (the stop bit) is 1, the block pulls data low during an eleventh clock pulse as the acknowledge. It then releases data and pulses `rx_valid`, with the byte in `rx_data`; bit 0 of the byte is the first bit received.
- R7: `rx_par_err` is 1 with `rx_valid` exactly when the received data bits and the parity bit hold an even number of ones.
- R8: If the stop-bit sample is 0, the block keeps generating clock pulses without pulling data. At the end of the first released phase in which data reads high, it pulses `frame_err` to ask for a resend, and `rx_valid` does not pulse.
- R9: After reset and outside frames, both `ps_clk_pull` and `ps_data_pull` are 0.
- R10: While `tx_ready` is low, a held `tx_valid` produces no clock pulses and no busy state. The byte is sent intact once the lines allow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ps_clk_in | input | 1 | Level read back from the clock line |
| ps_data_in | input | 1 | Level read back from the data line |
| ps_clk_pull | output | 1 | 1 pulls the clock line low |
| ps_data_pull | output | 1 | 1 pulls the data line low |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmit byte can be taken this cycle |
| tx_data | input | 8 | Byte to transmit |
| tx_busy | output | 1 | A transmit frame is in progress |
| tx_done | output | 1 | One-cycle pulse: the frame was sent completely |
| tx_abort | output | 1 | One-cycle pulse: the host took the clock, and the frame was dropped |
| rx_valid | output | 1 | One-cycle pulse: a received byte is available |
| rx_data | output | 8 | Received byte |
| rx_par_err | output | 1 | Parity of the byte given with `rx_valid` was wrong |
| frame_err | output | 1 | One-cycle pulse: a bad stop bit was seen; a resend is wanted |

## Verification
Contention is the hardest case to reach from the ports. The host has to seize the clock while the device has it released, and before the tenth falling edge. The bench's host model counts a random number of device falling edges, then waits past the next rising edge before it pulls the clock low. The frame-error recovery needs a host that keeps data low after the stop bit for several extra device clocks. The model does this, then releases data during a low phase, so the release is seen at the next sample.

// File: rtl/kbd_link_pkg.sv
package kbd_link_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HOLD,
    ST_TX_HI,
    ST_TX_LO,
    ST_RX_WAIT,
    ST_RX_LO,
    ST_RX_HI,
    ST_ACK_LO,
    ST_ACK_HI,
    ST_FE_LO,
    ST_FE_HI
  } link_state_t;

  // parity bit that makes data plus parity carry an odd count of ones
  function automatic logic odd_par(input logic [7:0] d);
    return ~(^d);
  endfunction

endpackage

// File: rtl/kbd_line_sync.sv
module kbd_line_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] synced
);
  // lines idle high, so reset every stage to 1
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/kbd_half_timer.sv
module kbd_half_timer #(
  parameter int HALF_CYC = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int CW = $clog2(HALF_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (restart || tick)  cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end

  // R5: phases are HALF_CYC long, so ticks are never back to back
  a_r5_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/kbd_link_phy.sv
module kbd_link_phy
  import kbd_link_pkg::*;
#(
  parameter int HALF_CYC = 4000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ps_clk_in,
  input  logic       ps_data_in,
  output logic       ps_clk_pull,
  output logic       ps_data_pull,
  input  logic       tx_valid,
  output logic       tx_ready,
  input  logic [7:0] tx_data,
  output logic       tx_busy,
  output logic       tx_done,
  output logic       tx_abort,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       rx_par_err,
  output logic       frame_err
);
  localparam int FRAME_BITS = 11;
  localparam int RX_BITS    = 10;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam logic [IDX_W-1:0] TX_LAST  = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] TX_GUARD = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] RX_LAST  = IDX_W'(RX_BITS - 1);

  link_state_t           state;
  logic [IDX_W-1:0]      bit_idx;
  logic [FRAME_BITS-1:0] sh_tx;
  logic [RX_BITS-1:0]    sh_rx;
  logic [1:0]            lines_s;
  logic                  clk_s, data_s, tick;

  kbd_line_sync #(.LINES(2), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .raw({ps_data_in, ps_clk_in}), .synced(lines_s)
  );
  assign clk_s  = lines_s[0];
  assign data_s = lines_s[1];

  kbd_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(state == ST_IDLE), .tick(tick)
  );

  assign tx_ready = (state == ST_IDLE) && clk_s && data_s;
  assign tx_busy  = (state == ST_TX_HI) || (state == ST_TX_LO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      bit_idx      <= '0;
      sh_tx        <= '0;
      sh_rx        <= '0;
      ps_clk_pull  <= 1'b0;
      ps_data_pull <= 1'b0;
      tx_done      <= 1'b0;
      tx_abort     <= 1'b0;
      rx_valid     <= 1'b0;
      rx_data      <= '0;
      rx_par_err   <= 1'b0;
      frame_err    <= 1'b0;
    end else begin
      tx_done   <= 1'b0;
      tx_abort  <= 1'b0;
      rx_valid  <= 1'b0;
      frame_err <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (clk_s && !data_s) begin
            state <= ST_RX_WAIT;               // host asks to send
          end else if (tx_valid && tx_ready) begin
            sh_tx        <= {1'b1, odd_par(tx_data), tx_data, 1'b0};
            bit_idx      <= '0;
            ps_data_pull <= 1'b1;              // start bit is 0
            state        <= ST_TX_HI;
          end
        end
        ST_TX_HI: if (tick) begin
          if (bit_idx < TX_GUARD && !clk_s) begin
            ps_clk_pull  <= 1'b0;
            ps_data_pull <= 1'b0;
            tx_abort     <= 1'b1;
            state        <= ST_HOLD;
          end else begin
            ps_clk_pull <= 1'b1;
            state       <= ST_TX_LO;
          end
        end
        ST_TX_LO: if (tick) begin
          ps_clk_pull <= 1'b0;
          if (bit_idx == TX_LAST) begin
            ps_data_pull <= 1'b0;
            tx_done      <= 1'b1;
            state        <= ST_HOLD;
          end else begin
            bit_idx      <= bit_idx + 1'b1;
            sh_tx        <= sh_tx >> 1;
            ps_data_pull <= ~sh_tx[1];
            state        <= ST_TX_HI;
          end
        end
        ST_RX_WAIT: if (tick) begin
          bit_idx     <= '0;
          ps_clk_pull <= 1'b1;
          state       <= ST_RX_LO;
        end
        ST_RX_LO: if (tick) begin
          ps_clk_pull <= 1'b0;
          state       <= ST_RX_HI;
        end
        ST_RX_HI: if (tick) begin
          sh_rx       <= {data_s, sh_rx[RX_BITS-1:1]};
          ps_clk_pull <= 1'b1;
          if (bit_idx == RX_LAST) begin
            if (data_s) begin
              ps_data_pull <= 1'b1;            // acknowledge
              state        <= ST_ACK_LO;
            end else begin
              state <= ST_FE_LO;
            end
          end else begin
            bit_idx <= bit_idx + 1'b1;
            state   <= ST_RX_LO;
          end
        end
        ST_ACK_LO: if (tick) begin
          ps_clk_pull <= 1'b0;
          state       <= ST_ACK_HI;
        end
        ST_ACK_HI: if (tick) begin
          ps_data_pull <= 1'b0;
          rx_valid     <= 1'b1;
          rx_data      <= sh_rx[7:0];
          rx_par_err   <= (odd_par(sh_rx[7:0]) != sh_rx[8]);
          state        <= ST_HOLD;
        end
        ST_FE_LO: if (tick) begin
          ps_clk_pull <= 1'b0;
          state       <= ST_FE_HI;
        end
        ST_FE_HI: if (tick) begin
          if (data_s) begin
            frame_err <= 1'b1;
            state     <= ST_HOLD;
          end else begin
            ps_clk_pull <= 1'b1;
            state       <= ST_FE_LO;
          end
        end
        ST_HOLD: if (tick) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4: an abort leaves both lines released
  a_r4_abort_release: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |-> (!ps_clk_pull && !ps_data_pull));
  // R4: aborts happen only before the tenth falling edge
  a_r4_abort_early: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |-> (bit_idx < TX_GUARD));
  // R2: completion events never coincide
  a_r2_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_done, tx_abort, rx_valid, frame_err}));
  // R6: a delivered byte was acknowledged by pulling data
  a_r6_ack_pulled: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(ps_data_pull));
  // R8: frame error is reported only after data was seen high
  a_r8_fe_release: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> $past(data_s));
  // R1: a transmit only begins from released lines
  a_r1_tx_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(clk_s && data_s));
  // R5: a generated clock-low phase lasts more than one cycle
  a_r5_low_min: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ps_clk_pull) |=> ps_clk_pull);
endmodule

// File: tb/tb_kbd_link_phy.sv
`timescale 1ns/1ps
module tb_kbd_link_phy;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic h_clk = 1'b0, h_data = 1'b0;
  logic tx_valid = 1'b0;
  logic [7:0] tx_data = '0;
  logic ps_clk_pull, ps_data_pull, tx_ready, tx_busy, tx_done, tx_abort;
  logic rx_valid, rx_par_err, frame_err;
  logic [7:0] rx_data;
  wire clk_line  = ~(ps_clk_pull | h_clk);
  wire data_line = ~(ps_data_pull | h_data);

  int checks = 0, fails = 0;
  int n_done = 0, n_abort = 0, n_fe = 0, n_rxv = 0;
  bit meas_en = 0, fin = 0;
  time t_fall = 0;

  kbd_link_phy #(.HALF_CYC(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .ps_clk_in(clk_line), .ps_data_in(data_line),
    .ps_clk_pull(ps_clk_pull), .ps_data_pull(ps_data_pull),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_busy(tx_busy), .tx_done(tx_done), .tx_abort(tx_abort),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_par_err(rx_par_err),
    .frame_err(frame_err)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (tx_done)   n_done++;
    if (tx_abort)  n_abort++;
    if (frame_err) n_fe++;
    if (rx_valid)  n_rxv++;
  end

  function automatic logic odd_bit(input logic [7:0] d);
    return ~(^d);
  endfunction

  function automatic logic [10:0] exp_frame(input logic [7:0] d);
    return {1'b1, odd_bit(d), d, 1'b0};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R5: measure generated clock-low phases
  always @(negedge clk_line) t_fall = $time;
  always @(posedge clk_line)
    if (meas_en && !h_clk)
      chk(($time - t_fall) == HALF * 10, "R5 low phase", int'($time - t_fall), HALF * 10);

  task automatic wait_ready();
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
  endtask

  task automatic tx_frame(input logic [7:0] b, input bit inhibit_first);
    logic [10:0] got;
    int d0;
    bit bad;
    d0 = n_done;
    if (inhibit_first) begin
      h_clk = 1'b1;
      repeat (6) @(negedge clk);
    end
    @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = b;
    if (inhibit_first) begin
      bad = 0;
      repeat (40) begin
        @(negedge clk);
        if (tx_ready || ps_clk_pull || tx_busy) bad = 1;
      end
      chk(!bad, "R10 held while inhibited", int'(bad), 0);
      chk(!tx_ready, "R1 ready low under inhibit", int'(tx_ready), 0);
      h_clk = 1'b0;
    end
    while (!tx_ready) @(negedge clk);
    @(posedge clk);
    #1 tx_valid = 1'b0;
    for (int i = 0; i < 11; i++) begin
      @(negedge clk_line);
      got[i] = data_line;
    end
    chk(got[0] == 1'b0, "R2 start bit", int'(got[0]), 0);
    chk(got[8:1] == b, "R2 data bits", int'(got[8:1]), int'(b));
    chk(got[9] == odd_bit(b), "R3 parity bit", int'(got[9]), int'(odd_bit(b)));
    chk(got[10] == 1'b1, "R2 stop bit", int'(got[10]), 1);
    if (inhibit_first) chk(got == exp_frame(b), "R10 frame intact", int'(got), int'(exp_frame(b)));
    repeat (2 * HALF + 4) @(negedge clk);
    chk(n_done == d0 + 1, "R2 done pulse", n_done - d0, 1);
  endtask

  task automatic host_send(input logic [7:0] b, input bit bad_par, input bit bad_stop);
    logic [9:0] bits;
    int v0, f0;
    bits = {~bad_stop, odd_bit(b) ^ bad_par, b};
    v0 = n_rxv;
    f0 = n_fe;
    wait_ready();
    h_data = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk_line);
      #1 h_data = ~bits[i];
    end
    if (!bad_stop) begin
      @(negedge clk_line);
      #1 chk(data_line == 1'b0, "R6 ack pulls data", int'(data_line), 0);
      while (n_rxv == v0) @(negedge clk);
      chk(rx_data == b, "R6 received byte", int'(rx_data), int'(b));
      chk(rx_par_err == bad_par, "R7 parity flag", int'(rx_par_err), int'(bad_par));
    end else begin
      repeat (2) @(negedge clk_line);
      chk(ps_data_pull == 1'b0, "R8 no ack on bad stop", int'(ps_data_pull), 0);
      #1 h_data = 1'b0;
      repeat (4 * HALF) @(negedge clk);
      chk(n_fe == f0 + 1, "R8 frame error pulse", n_fe - f0, 1);
      chk(n_rxv == v0, "R8 no byte delivered", n_rxv - v0, 0);
    end
  endtask

  task automatic contend(input logic [7:0] b, input int k);
    int a0, d0;
    a0 = n_abort;
    d0 = n_done;
    wait_ready();
    tx_valid = 1'b1;
    tx_data  = b;
    @(posedge clk);
    #1 tx_valid = 1'b0;
    repeat (k) @(negedge clk_line);
    repeat (HALF + 2) @(posedge clk);
    #1 h_clk = 1'b1;
    repeat (3 * HALF) @(negedge clk);
    chk(n_abort == a0 + 1, "R4 abort pulse", n_abort - a0, 1);
    chk(n_done == d0, "R4 no done after abort", n_done - d0, 0);
    chk(!ps_clk_pull && !ps_data_pull, "R4 lines released",
        int'({ps_clk_pull, ps_data_pull}), 0);
    chk(!tx_ready, "R1 ready low while clock held", int'(tx_ready), 0);
    h_clk = 1'b0;
    wait_ready();
  endtask

  initial begin
    void'($urandom(32'h5eed_0017));
    repeat (3) @(negedge clk);
    chk(!ps_clk_pull && !ps_data_pull, "R9 reset pulls", int'({ps_clk_pull, ps_data_pull}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(tx_ready == 1'b1, "R1 ready when lines high", int'(tx_ready), 1);
    chk(!ps_clk_pull && !ps_data_pull, "R9 idle pulls", int'({ps_clk_pull, ps_data_pull}), 0);

    // directed corners
    meas_en = 1;
    tx_frame(8'h00, 0);
    tx_frame(8'hFF, 0);
    meas_en = 0;
    tx_frame(8'hA5, 1);
    host_send(8'hED, 0, 0);
    host_send(8'h00, 1, 0);
    host_send(8'h3C, 0, 1);
    contend(8'h55, 1);
    contend(8'h55, 9);

    // random mix
    for (int n = 0; n < 40; n++) begin
      int kind;
      kind = int'($urandom_range(0, 9));
      if (kind < 4)       tx_frame(8'($urandom), 0);
      else if (kind < 7)  host_send(8'($urandom), ($urandom_range(0, 3) == 0), 0);
      else if (kind < 8)  host_send(8'($urandom), 0, 1);
      else if (kind < 9)  contend(8'($urandom), int'($urandom_range(1, 9)));
      else                tx_frame(8'($urandom), 1);
      repeat (HALF) @(negedge clk);
      chk(!ps_clk_pull && !ps_data_pull, "R9 released between frames",
          int'({ps_clk_pull, ps_data_pull}), 0);
    end

    fin = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #1500000;
    if (!fin) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule